// File: doc/BRIEF.md
# Configurable GPIO Pad Controller

This block holds the control logic for a bank of general-purpose I/O pins. Software programs a small register set over a synchronous write bus. The registers are an output latch, a per-pin digital/analog mode bit, a per-pin push-pull/open-drain bit and a global word that carries a routing gate and a pull-up kill switch. From these the block derives, for every pin, a high-side drive enable, a low-side drive enable, a weak pull-up enable and a digital receiver enable. These signals go to the analog pad cell, which is outside this block.

Each pin's output value comes either from the latch or from an on-chip peripheral, as a per-pin select input chooses. The select only takes effect while routing is enabled. While routing is disabled, no driver is ever switched on. Pad levels come back through a two-stage synchronizer. Before software sees them they are masked so that analog pins read as zero.

Top module: `pad_bank_ctrl`

## Requirements
- R1: After reset, every drive enable is 0 and every pull-up and receiver enable is 1. Registers read back as latch all 1s, mode all 1s (digital), output mode all 0s and global word 0.
- R2: While global bit 0 (routing enable) is 0, the high-side and low-side enables of every pin are 0.
- R3: A pin whose mode bit is 0 (analog) has its high-side, low-side, pull-up and receiver enables at 0.
- R4: The read-back register (address 4) returns 0 for every analog pin, whatever its pad level, starting in the cycle after the mode write.
- R5: A digital pin with output-mode bit 1 (push-pull) and routing enabled asserts high-side drive for output value 1 and low-side drive for output value 0.
- R6: A digital pin with output-mode bit 0 (open-drain) never asserts high-side drive. It asserts low-side drive only for output value 0.
- R7: The pull-up enable of a digital pin is 0 while its low-side drive is on. It is 0 on every pin while global bit 1 (pull-up disable) is 1.
- R8: For a digital pin, the read-back register returns the pad level, not the output value. A pad change becomes visible after the second rising clock edge that follows it.
- R9: With routing enabled, a pin whose peripheral-select bit is 1 takes its output value from the peripheral output bit. A pin whose select bit is 0 takes it from the latch.
- R10: The register map is: latch at address 0, mode at 1, output mode at 2, global word at 3 (bit 0 routing enable, bit 1 pull-up disable, other bits read 0), read-back at 4. Writes to address 4 or above change nothing, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NPINS | Register read data (combinational) |
| periph_sel | input | NPINS | Per-pin select: 1 takes the peripheral value |
| periph_out | input | NPINS | Per-pin peripheral output value |
| pad_in | input | NPINS | Pad level seen by the receiver |
| drv_hi | output | NPINS | High-side drive enable |
| drv_lo | output | NPINS | Low-side drive enable |
| pull_en | output | NPINS | Weak pull-up enable |
| rx_en | output | NPINS | Digital receiver enable |

## Verification
A pad transition can still be in the synchronizer pipeline when a mode write turns that pin analog. The bench sets up this overlap directly. It raises an external level on one undriven pin while pull-ups are disabled, then times the mode write so that it lands on the same edge that moves the new level into the last synchronizer stage. The read-back must show 0 for that pin at once and must show the pad level again as soon as the pin returns to digital. Separately, a change of the peripheral value on a routed pin is checked against drive enables that are predicted from the requirements.

// File: rtl/pad_pkg.sv
package pad_pkg;

    // Register address width and map
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_LATCH  = 3'd0,
        REG_MODE   = 3'd1,
        REG_DRIVE  = 3'd2,
        REG_GLOBAL = 3'd3,
        REG_PADS   = 3'd4
    } reg_sel_e;

    // Bit positions inside the global word
    localparam int GLB_ROUTE_BIT = 0;
    localparam int GLB_PULL_BIT  = 1;

    typedef struct packed {
        logic pull_off;
        logic route_on;
    } glob_cfg_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic pull;
        logic rx;
    } pin_ctl_t;

    // Output value: the peripheral wins only when routing is on and selected
    function automatic logic pick_value(input logic latch_v, input logic periph_v,
                                        input logic sel, input logic route_on);
        return (route_on && sel) ? periph_v : latch_v;
    endfunction

    // Driver and receiver controls of one pin
    function automatic pin_ctl_t pin_control(input logic value, input logic digital,
                                             input logic push_pull, input glob_cfg_t g);
        pin_ctl_t c;
        c.hi   = g.route_on & digital & push_pull & value;
        c.lo   = g.route_on & digital & ~value;
        c.pull = digital & ~g.pull_off & ~c.lo;
        c.rx   = digital;
        return c;
    endfunction

endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
    import pad_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] latch_q,
    output logic [NPINS-1:0] digital_q,
    output logic [NPINS-1:0] pushpull_q,
    output glob_cfg_t        glob_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q    <= '1;
            digital_q  <= '1;
            pushpull_q <= '0;
            glob_q     <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_LATCH:  latch_q    <= wr_data;
                REG_MODE:   digital_q  <= wr_data;
                REG_DRIVE:  pushpull_q <= wr_data;
                REG_GLOBAL: begin
                    glob_q.route_on <= wr_data[GLB_ROUTE_BIT];
                    glob_q.pull_off <= wr_data[GLB_PULL_BIT];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pad_in_sync.sv
module pad_in_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);

    logic [NPINS-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/pad_pin_cell.sv
module pad_pin_cell
    import pad_pkg::*;
(
    input  logic      latch_v,
    input  logic      periph_v,
    input  logic      sel,
    input  logic      digital,
    input  logic      push_pull,
    input  glob_cfg_t glob,
    output logic      drv_hi,
    output logic      drv_lo,
    output logic      pull_en,
    output logic      rx_en
);

    logic     value;
    pin_ctl_t ctl;

    always_comb begin
        value = pick_value(latch_v, periph_v, sel, glob.route_on);
        ctl   = pin_control(value, digital, push_pull, glob);
    end

    assign drv_hi  = ctl.hi;
    assign drv_lo  = ctl.lo;
    assign pull_en = ctl.pull;
    assign rx_en   = ctl.rx;

endmodule

// File: rtl/pad_bank_ctrl.sv
module pad_bank_ctrl
    import pad_pkg::*;
#(
    parameter int NPINS       = 8,  // at least 2 (global word needs two bits)
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  periph_sel,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  drv_hi,
    output logic [NPINS-1:0]  drv_lo,
    output logic [NPINS-1:0]  pull_en,
    output logic [NPINS-1:0]  rx_en
);

    localparam int GLB_PAD = NPINS - 2;

    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] digital_q;
    logic [NPINS-1:0] pushpull_q;
    glob_cfg_t        glob_q;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] readback;

    pad_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .latch_q    (latch_q),
        .digital_q  (digital_q),
        .pushpull_q (pushpull_q),
        .glob_q     (glob_q)
    );

    pad_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pad_pin_cell u_cell (
            .latch_v   (latch_q[i]),
            .periph_v  (periph_out[i]),
            .sel       (periph_sel[i]),
            .digital   (digital_q[i]),
            .push_pull (pushpull_q[i]),
            .glob      (glob_q),
            .drv_hi    (drv_hi[i]),
            .drv_lo    (drv_lo[i]),
            .pull_en   (pull_en[i]),
            .rx_en     (rx_en[i])
        );
    end

    // Analog pins are masked with the current mode, so a switch takes effect at once
    assign readback = pad_sync & digital_q;

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_LATCH:  rd_data = latch_q;
            REG_MODE:   rd_data = digital_q;
            REG_DRIVE:  rd_data = pushpull_q;
            REG_GLOBAL: rd_data = {{GLB_PAD{1'b0}}, glob_q.pull_off, glob_q.route_on};
            REG_PADS:   rd_data = readback;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pad_bank_chk.sv
module pad_bank_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             route_on,
    input logic             pull_off,
    input logic [NPINS-1:0] digital,
    input logic [NPINS-1:0] pushpull,
    input logic [NPINS-1:0] periph_sel,
    input logic [NPINS-1:0] periph_out,
    input logic [NPINS-1:0] readback,
    input logic [NPINS-1:0] drv_hi,
    input logic [NPINS-1:0] drv_lo,
    input logic [NPINS-1:0] pull_en,
    input logic [NPINS-1:0] rx_en
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (drv_hi == '0 && drv_lo == '0 && pull_en == '1 && rx_en == '1)); // R1

    AST_ROUTE_GATE: assert property (@(posedge clk) disable iff (rst)
        !route_on |-> (drv_hi == '0 && drv_lo == '0)); // R2

    AST_ANALOG_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        ((drv_hi | drv_lo | pull_en | rx_en) & ~digital) == '0); // R3

    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (readback & ~digital) == '0); // R4

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (drv_hi & drv_lo) == '0); // R5

    AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (drv_hi & ~pushpull) == '0); // R6

    AST_PULL_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (pull_en & drv_lo) == '0); // R7

    AST_PULL_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
        pull_off |-> pull_en == '0); // R7

    AST_PERIPH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        route_on |-> ((periph_sel & digital & pushpull) & (drv_hi ^ periph_out)) == '0); // R9

endmodule

bind pad_bank_ctrl pad_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .route_on   (glob_q.route_on),
    .pull_off   (glob_q.pull_off),
    .digital    (digital_q),
    .pushpull   (pushpull_q),
    .periph_sel (periph_sel),
    .periph_out (periph_out),
    .readback   (readback),
    .drv_hi     (drv_hi),
    .drv_lo     (drv_lo),
    .pull_en    (pull_en),
    .rx_en      (rx_en)
);

// File: tb/pad_bank_ctrl_tb.sv
`timescale 1ns/1ps
module pad_bank_ctrl_tb;

    localparam int N = 8;
    localparam int K_RD = 0, K_HI = 1, K_LO = 2, K_PU = 3, K_RX = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic [N-1:0] periph_sel = '0;
    logic [N-1:0] periph_out = '0;
    logic [N-1:0] pad;
    logic [N-1:0] drv_hi, drv_lo, pull_en, rx_en;
    logic [N-1:0] ext_en = '0;
    logic [N-1:0] ext_val = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int           kind;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    // Resolved pad: own drivers, then an external source, then the weak pull-up
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (drv_hi[i])      pad[i] = 1'b1;
            else if (drv_lo[i]) pad[i] = 1'b0;
            else if (ext_en[i]) pad[i] = ext_val[i];
            else if (pull_en[i]) pad[i] = 1'b1;
            else                pad[i] = 1'b0;
        end
    end

    pad_bank_ctrl #(.NPINS(N)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .periph_sel (periph_sel),
        .periph_out (periph_out),
        .pad_in     (pad),
        .drv_hi     (drv_hi),
        .drv_lo     (drv_lo),
        .pull_en    (pull_en),
        .rx_en      (rx_en)
    );

    // Monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [N-1:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_HI:    act = drv_hi;
                    K_LO:    act = drv_lo;
                    K_PU:    act = pull_en;
                    default: act = rx_en;
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [N-1:0] e, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [N-1:0] d);
        tick();
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [N-1:0] e, input string tag);
        tick();
        rd_addr = a;
        push(K_RD, e, tag);
    endtask

    task automatic expect_pins(input logic [N-1:0] hi, input logic [N-1:0] lo,
                               input logic [N-1:0] pu, input logic [N-1:0] rx,
                               input string tag);
        push(K_HI, hi, tag);
        push(K_LO, lo, tag);
        push(K_PU, pu, tag);
        push(K_RX, rx, tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1: reset state at the pins and in the registers
        expect_pins(8'h00, 8'h00, 8'hFF, 8'hFF, "R1 reset pins");
        expect_reg(3'd0, 8'hFF, "R1 latch reset");
        expect_reg(3'd1, 8'hFF, "R1 mode reset");
        expect_reg(3'd2, 8'h00, "R1 drive reset");
        expect_reg(3'd3, 8'h00, "R1 global reset");

        // R2: latch low on upper pins, routing off: no driver
        reg_wr(3'd0, 8'h0F);
        expect_pins(8'h00, 8'h00, 8'hFF, 8'hFF, "R2 gate closed");

        // R6: routing on, open-drain
        reg_wr(3'd3, 8'h01);
        expect_pins(8'h00, 8'hF0, 8'h0F, 8'hFF, "R6 open-drain");

        // R5: push-pull
        reg_wr(3'd2, 8'hFF);
        expect_pins(8'h0F, 8'hF0, 8'h0F, 8'hFF, "R5 push-pull");

        // R3: pins 2..5 analog
        reg_wr(3'd1, 8'hC3);
        expect_pins(8'h03, 8'hC0, 8'h03, 8'hC3, "R3 analog isolation");

        // R4: analog pins read 0 though their pads are high
        ext_en  = 8'h3C;
        ext_val = 8'h3C;
        tick();
        tick();
        expect_reg(3'd4, 8'h03, "R4 analog reads zero");
        ext_en = '0;

        // R8: open-drain latch 1, external low on pin 0, two-edge latency
        reg_wr(3'd1, 8'hFF);
        reg_wr(3'd2, 8'h00);
        reg_wr(3'd0, 8'hFF);
        tick();
        tick();
        tick();
        ext_en  = 8'h01;
        ext_val = 8'h00;
        rd_addr = 3'd4;
        push(K_RD, 8'hFF, "R8 before first edge");
        tick();
        push(K_RD, 8'hFF, "R8 after first edge");
        tick();
        push(K_RD, 8'hFE, "R8 pad level after second edge");
        push(K_LO, 8'h00, "R8 pin not driving");

        // R7: global pull-up disable
        reg_wr(3'd3, 8'h03);
        push(K_PU, 8'h00, "R7 global pull-up off");
        expect_reg(3'd3, 8'h03, "R10 global word read");
        ext_en = '0;

        // Overlap: pad change in the synchronizer while the pin turns analog
        tick();
        tick();
        tick();
        ext_en  = 8'h08;
        ext_val = 8'h08;
        tick();
        wr_en   = 1'b1;
        wr_addr = 3'd1;
        wr_data = 8'hF7;
        tick();
        wr_en   = 1'b0;
        rd_addr = 3'd4;
        push(K_RD, 8'h00, "R4 analog switch during sync");
        reg_wr(3'd1, 8'hFF);
        expect_reg(3'd4, 8'h08, "R8 digital again");
        ext_en = '0;

        // R7: low drive turns the pull-up off on that pin
        reg_wr(3'd3, 8'h01);
        reg_wr(3'd0, 8'hF0);
        expect_pins(8'h00, 8'h0F, 8'hF0, 8'hFF, "R7 pull off when low");

        // R9: peripheral routing
        reg_wr(3'd2, 8'hFF);
        reg_wr(3'd0, 8'h00);
        tick();
        periph_out = 8'hFF;
        periph_sel = 8'h0F;
        expect_pins(8'h0F, 8'hF0, 8'h0F, 8'hFF, "R9 periph select");
        tick();
        periph_out = 8'h0A;
        expect_pins(8'h0A, 8'hF5, 8'h0A, 8'hFF, "R9 periph value change");

        // R2: routing off again overrides everything
        reg_wr(3'd3, 8'h00);
        expect_pins(8'h00, 8'h00, 8'hFF, 8'hFF, "R2 gate closed with periph");
        periph_sel = '0;

        // R10: write to read-back ignored, unused address reads zero
        reg_wr(3'd4, 8'h55);
        reg_wr(3'd5, 8'h55);
        expect_reg(3'd0, 8'h00, "R10 latch untouched");
        expect_reg(3'd1, 8'hFF, "R10 mode untouched");
        expect_reg(3'd2, 8'hFF, "R10 drive untouched");
        expect_reg(3'd3, 8'h00, "R10 global untouched");
        expect_reg(3'd4, 8'hFF, "R10 read-back untouched");
        expect_reg(3'd5, 8'h00, "R10 unused reads zero");

        tick();
        tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule